// File: doc/BRIEF.md
# Byte-Serial CRC-32 Generator and Checker

The block folds one message byte per clock into a 32-bit cyclic redundancy remainder using the widely deployed Ethernet-style polynomial. The register is kept in reflected form: it shifts right, absorbs each byte least significant bit first, and applies eight single-bit division steps in one cycle through unrolled combinational logic. A start pulse presets the register to all ones. A valid byte that also carries the end strobe closes the message.

When a message closes, the block emits the complemented remainder as four check bytes, least significant byte first, on a dedicated byte output with its own valid strobe. A sender appends these bytes to the message. A receiver streams the message and its appended check bytes through the same block. One cycle after the closing byte it reports whether the register reached the fixed good residue, which is nonzero because the check bytes were complemented.

Top module: `crc32_byte_engine`

## Requirements
- R1: While rst_ni is low and after its release, fcs_valid_o, check_valid_o and check_ok_o are 0 until a message closes.
- R2: The register is preset to 0xFFFFFFFF by start_i and updated per byte with the reflected polynomial 0xEDB88320, bit 0 of data_i first. The nine ASCII bytes "123456789" give the checksum 0xCBF43926.
- R3: A byte on data_i is absorbed only on a clock edge where valid_i is 1. Idle cycles, and data_i changing while valid_i is 0, leave the result unchanged.
- R4: When start_i and valid_i are both 1 on the same edge, the register is preset first and that byte is then absorbed as the first byte of the new message.
- R5: The message closes on an edge where valid_i and last_i are both 1. fcs_valid_o is then 1 for exactly four cycles, starting on the cycle after that edge. fcs_o carries checksum bits [7:0], [15:8], [23:16] and [31:24] in that order.
- R6: The checksum is the bitwise complement of the register value after the closing byte.
- R7: check_valid_o is 1 for one cycle, the cycle after the closing edge. check_ok_o is 1 in that cycle exactly when the register after the closing byte equals 0xDEBB20E3, which is the case for any message followed by its own four check bytes. check_ok_o is 0 whenever check_valid_o is 0.
- R8: A message with its check bytes in which any single bit is corrupted gives check_ok_o = 0.
- R9: last_i has no effect while valid_i is 0: no check bytes are emitted and check_valid_o stays 0.
- R10: A one-byte message closes correctly: the single byte 0x00 gives the checksum 0xD202EF8D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Preset the register for a new message |
| valid_i | input | 1 | data_i holds a message byte this cycle |
| last_i | input | 1 | With valid_i, marks the closing byte |
| data_i | input | 8 | Message byte |
| fcs_o | output | 8 | Check byte, least significant first |
| fcs_valid_o | output | 1 | fcs_o is valid |
| check_valid_o | output | 1 | Receive verdict is valid |
| check_ok_o | output | 1 | Register matched the good residue |

## Verification
The bench builds the block with its default parameters: a 32-bit register, 8-bit bytes, the reflected polynomial, the all-ones preset and the reflected residue. These defaults allow known published check values to be compared directly, including the nine-digit string and a single zero byte. They also allow the closed loop, in which the block's own emitted check bytes are fed back and must land on the residue. Random messages with idle gaps, start pulses that coincide with the first byte, and closings that arrive while check bytes are still being emitted exercise the priority and restart rules against a behavioural model.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
  parameter int          CRC_WIDTH      = 32;
  parameter int          BYTE_WIDTH     = 8;
  parameter logic [31:0] POLY_REFLECTED = 32'hEDB88320;
  parameter logic [31:0] PRESET_ONES    = 32'hFFFFFFFF;
  parameter logic [31:0] GOOD_RESIDUE   = 32'hDEBB20E3;
endpackage

// File: rtl/crc32_byte_step.sv
// Eight (DATA_W) reflected division steps unrolled into one combinational stage.
module crc32_byte_step #(
  parameter int               CRC_W  = 32,
  parameter int               DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY   = 32'hEDB88320
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [0:DATA_W];

  assign stage[0] = crc_i ^ {{(CRC_W-DATA_W){1'b0}}, data_i};

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign stage[g+1] = (stage[g] >> 1) ^ (stage[g][0] ? POLY : '0);
  end

  assign crc_o = stage[DATA_W];
endmodule

// File: rtl/crc32_fcs_ser.sv
// Loads a complemented remainder and shifts it out low byte first.
module crc32_fcs_ser #(
  parameter int CRC_W  = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CRC_W-1:0]  word_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              valid_o
);
  localparam int NUM_BYTES = CRC_W / DATA_W;
  localparam int CNT_W     = $clog2(NUM_BYTES + 1);

  logic [CRC_W-1:0] shreg_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      shreg_q <= word_i;
      cnt_q   <= CNT_W'(NUM_BYTES);
    end else if (cnt_q != '0) begin
      shreg_q <= shreg_q >> DATA_W;
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign byte_o  = shreg_q[DATA_W-1:0];
  assign valid_o = (cnt_q != '0);
endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine
  import crc32_pkg::*;
#(
  parameter int               CRC_W   = CRC_WIDTH,
  parameter int               DATA_W  = BYTE_WIDTH,
  parameter logic [CRC_W-1:0] POLY    = POLY_REFLECTED,
  parameter logic [CRC_W-1:0] PRESET  = PRESET_ONES,
  parameter logic [CRC_W-1:0] RESIDUE = GOOD_RESIDUE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] fcs_o,
  output logic              fcs_valid_o,
  output logic              check_valid_o,
  output logic              check_ok_o
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic [CRC_W-1:0] seed, stepped;
  logic             close_w;
  logic             check_valid_q, check_ok_q;

  // start wins: the preset is the seed for a byte arriving on the same edge
  assign seed    = start_i ? PRESET : crc_q;
  assign close_w = valid_i & last_i;

  crc32_byte_step #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W),
    .POLY  (POLY)
  ) u_step (
    .crc_i (seed),
    .data_i(data_i),
    .crc_o (stepped)
  );

  always_comb begin
    crc_d = crc_q;
    if (valid_i)      crc_d = stepped;
    else if (start_i) crc_d = PRESET;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q         <= PRESET;
      check_valid_q <= 1'b0;
      check_ok_q    <= 1'b0;
    end else begin
      crc_q         <= crc_d;
      check_valid_q <= close_w;
      check_ok_q    <= close_w & (stepped == RESIDUE);
    end
  end

  crc32_fcs_ser #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W)
  ) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (close_w),
    .word_i (~stepped),
    .byte_o (fcs_o),
    .valid_o(fcs_valid_o)
  );

  assign check_valid_o = check_valid_q;
  assign check_ok_o    = check_ok_q;
endmodule

// File: rtl/crc32_engine_chk.sv
module crc32_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic last_i,
  input logic fcs_valid_o,
  input logic check_valid_o,
  input logic check_ok_o
);
  p_check_after_close_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> check_valid_o);

  p_check_needs_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_valid_o |-> $past(valid_i && last_i));

  p_ok_qualified_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_ok_o |-> check_valid_o);

  p_fcs_after_close_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> fcs_valid_o);

  p_fcs_only_continues_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcs_valid_o && !$past(valid_i && last_i)) |-> $past(fcs_valid_o));
endmodule

bind crc32_byte_engine crc32_engine_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .last_i       (last_i),
  .fcs_valid_o  (fcs_valid_o),
  .check_valid_o(check_valid_o),
  .check_ok_o   (check_ok_o)
);

// File: tb/sim_crc32_byte_engine.sv
`timescale 1ns/1ps
module sim_crc32_byte_engine;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, valid_i = 1'b0, last_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] fcs_o;
  logic       fcs_valid_o, check_valid_o, check_ok_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  crc32_byte_engine u0 (
    .clk_i, .rst_ni, .start_i, .valid_i, .last_i, .data_i,
    .fcs_o, .fcs_valid_o, .check_valid_o, .check_ok_o
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // behavioural reference, advanced on every edge
  logic [31:0] m_crc, m_word;
  int          m_left;
  bit          m_cv, m_ok;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_crc = 32'hFFFFFFFF; m_word = '0; m_left = 0; m_cv = 0; m_ok = 0;
    end else begin
      if (start_i) m_crc = 32'hFFFFFFFF;
      if (valid_i) m_crc = ref_byte(m_crc, data_i);
      if (valid_i && last_i) begin
        m_word = ~m_crc; m_left = 4; m_cv = 1; m_ok = (m_crc == 32'hDEBB20E3);
      end else begin
        if (m_left > 0) begin m_word = m_word >> 8; m_left--; end
        m_cv = 0; m_ok = 0;
      end
    end
  end

  logic [7:0] got_fcs[$];
  int         verdicts = 0;
  bit         last_verdict = 0;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(fcs_valid_o == (m_left > 0), "R5 fcs_valid_o", 32'(fcs_valid_o), 32'(m_left > 0));
      if (m_left > 0) check(fcs_o == m_word[7:0], "R5 fcs_o", 32'(fcs_o), 32'(m_word[7:0]));
      check(check_valid_o == m_cv, "R7 check_valid_o", 32'(check_valid_o), 32'(m_cv));
      check(check_ok_o == m_ok, "R7 check_ok_o", 32'(check_ok_o), 32'(m_ok));
      if (fcs_valid_o) got_fcs.push_back(fcs_o);
      if (check_valid_o) begin verdicts++; last_verdict = check_ok_o; end
    end
  end

  task automatic drive(input logic st, input logic v, input logic l, input logic [7:0] d);
    @(negedge clk_i);
    start_i = st; valid_i = v; last_i = l; data_i = d;
  endtask

  task automatic idle(input int n);
    repeat (n) drive(1'b0, 1'b0, 1'b0, 8'($urandom));
  endtask

  task automatic send(input logic [7:0] msg[$], input bit start_with_first, input int gap);
    if (!start_with_first) drive(1'b1, 1'b0, 1'b0, 8'($urandom));
    foreach (msg[i]) begin
      drive(start_with_first && i == 0, 1'b1, i == msg.size() - 1, msg[i]);
      if (gap > 0 && i != msg.size() - 1)
        repeat (gap) drive(1'b0, 1'b0, 1'($urandom), 8'($urandom));  // last_i noise, R9
    end
  endtask

  function automatic logic [31:0] fcs_word();
    return {got_fcs[3], got_fcs[2], got_fcs[1], got_fcs[0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired got=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] digits[$];
    logic [7:0] rx[$];
    string s = "123456789";
    for (int i = 0; i < 9; i++) digits.push_back(s[i]);

    repeat (3) @(negedge clk_i);
    check(!fcs_valid_o && !check_valid_o && !check_ok_o, "R1 outputs in reset",
          {29'd0, fcs_valid_o, check_valid_o, check_ok_o}, 32'd0);
    rst_ni = 1'b1;
    idle(3);
    check(!fcs_valid_o && !check_valid_o && !check_ok_o, "R1 outputs after reset",
          {29'd0, fcs_valid_o, check_valid_o, check_ok_o}, 32'd0);

    // R2 R5 R6: known check value, separate start pulse
    got_fcs.delete();
    send(digits, 1'b0, 0);
    idle(7);
    check(got_fcs.size() == 4, "R5 byte count", got_fcs.size(), 4);
    if (got_fcs.size() == 4) check(fcs_word() == 32'hCBF43926, "R2 R6 checksum", fcs_word(), 32'hCBF43926);

    // R4 R7: start with first byte; message plus its check bytes lands on residue
    rx = digits;
    rx.push_back(8'h26); rx.push_back(8'h39); rx.push_back(8'hF4); rx.push_back(8'hCB);
    got_fcs.delete(); verdicts = 0;
    send(rx, 1'b1, 0);
    idle(7);
    check(verdicts == 1 && last_verdict, "R7 good frame verdict", {verdicts[30:0], last_verdict}, 32'd3);
    if (got_fcs.size() == 4) check(fcs_word() == 32'h2144DF1C, "R4 preset before byte", fcs_word(), 32'h2144DF1C);
    else check(0, "R4 byte count", got_fcs.size(), 4);

    // R3: gaps with data noise
    got_fcs.delete();
    send(digits, 1'b0, 3);
    idle(7);
    if (got_fcs.size() == 4) check(fcs_word() == 32'hCBF43926, "R3 gaps ignored", fcs_word(), 32'hCBF43926);
    else check(0, "R3 byte count", got_fcs.size(), 4);

    // R8: single-bit corruption
    for (int k = 0; k < 3; k++) begin
      logic [7:0] bad[$];
      bad = rx;
      bad[k * 5] = bad[k * 5] ^ (8'h01 << k);
      verdicts = 0;
      send(bad, 1'b0, k);
      idle(7);
      check(verdicts == 1 && !last_verdict, "R8 corrupted frame", {verdicts[30:0], last_verdict}, 32'd2);
    end

    // R9: last_i without valid_i
    got_fcs.delete(); verdicts = 0;
    drive(1'b0, 1'b0, 1'b1, 8'h55);
    drive(1'b0, 1'b0, 1'b1, 8'hAA);
    idle(6);
    check(got_fcs.size() == 0 && verdicts == 0, "R9 lone last_i", got_fcs.size() + verdicts, 0);

    // R10: one-byte message
    begin
      logic [7:0] one[$];
      one.push_back(8'h00);
      got_fcs.delete();
      send(one, 1'b1, 0);
      idle(7);
      if (got_fcs.size() == 4) check(fcs_word() == 32'hD202EF8D, "R10 single byte", fcs_word(), 32'hD202EF8D);
      else check(0, "R10 byte count", got_fcs.size(), 4);
    end

    // random traffic, closings may overlap emission; model checks every cycle
    for (int n = 0; n < 40; n++) begin
      logic [7:0] msg[$];
      int len = 1 + int'($urandom_range(0, 11));
      for (int i = 0; i < len; i++) msg.push_back(8'($urandom));
      send(msg, 1'($urandom), int'($urandom_range(0, 2)));
      idle(int'($urandom_range(0, 5)));
    end
    idle(8);
    finish_run();
  end
endmodule